// File: doc/BRIEF.md
# Task Preemption Controller

This block decides which inference task owns the compute array and how a running task is taken off it. Software places tasks into a small table of slots. Each entry holds a priority token count, the total number of tiles in the task, an estimated run time supplied from outside, and a per-task flag that permits the task to be terminated. The controller counts tile completions reported by the array. When the array is idle, it dispatches the best ready task.

When a preemption request arrives for the running task, the controller compares the tiles still outstanding against a programmable threshold. If few tiles remain, it lets the task finish (drain). Otherwise it terminates the task outright when termination is permitted (kill), and in all other cases it saves the task's context at the next tile boundary (checkpoint). Context moves through a save handshake and a restore handshake with an external agent. A restored task continues from the tile index that was saved. A killed task later starts again from tile zero.

Top module: `task_preempt_ctrl`

## Requirements
- R1: While rst_ni is low and after its release with no stimulus, run_valid_o, save_req_o, restore_req_o, act_valid_o and done_valid_o are all 0.
- R2: A submission writes its fields into slot sub_id_i and marks the slot ready only if that slot is empty and sub_tiles_i is nonzero. A submission to an occupied slot, or with zero tiles, leaves the table unchanged.
- R3: When nothing is running, the controller selects, among occupied slots, the highest token count first, then the smallest estimate, then the lowest slot number. The selected task shows on run_valid_o/run_id_o one cycle later. A task that has never been checkpointed starts at tile 0 with no restore handshake.
- R4: Each tile_done_i pulse while a task is running (including during drain and while waiting for a checkpoint boundary) advances run_tile_o by one. The pulse that brings the count to the total raises done_valid_o in the same cycle, with done_id_o set to the task. The slot is then freed and run_valid_o is 0 in the next cycle.
- R5: preempt_req_i in normal running raises act_valid_o in the same cycle. Let remaining = total minus the tiles completed, counting any tile_done_i of that cycle. act_o is 1 (drain) if remaining ≤ drain_thr_i; otherwise it is 2 (kill) if the task's kill enable is set; otherwise it is 0 (checkpoint).
- R6: After a drain decision, the task keeps running until it completes.
- R7: After a checkpoint decision, no save is requested until a tile boundary, meaning the next tile_done_i. If that tile completes the task, R4 applies. Otherwise save_req_o rises in the next cycle, with ctx_id_o set to the task and ctx_tile_o set to the tiles done, and stays high until save_ack_i. After the acknowledge the task is no longer running but stays ready.
- R8: Dispatching a checkpointed task raises restore_req_o, with ctx_tile_o set to the saved index, until restore_ack_i. The task then runs with run_tile_o starting at that index.
- R9: After a kill decision, run_valid_o is 0 in the next cycle and no save is requested. The task stays ready with progress 0 and is later dispatched at tile 0 without a restore.
- R10: preempt_req_i is ignored (act_valid_o stays 0) when no task is running, during drain, while waiting for a checkpoint boundary, and during either handshake.
- R11: save_req_o and restore_req_o are never high together. tile_done_i has no effect during a handshake or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_valid_i | input | 1 | Task submission strobe |
| sub_id_i | input | ID_W | Slot to fill |
| sub_tok_i | input | TOK_W | Priority token count |
| sub_tiles_i | input | TILE_W | Total tiles of the task |
| sub_est_i | input | EST_W | Estimated run time |
| sub_kill_en_i | input | 1 | Task may be terminated on preemption |
| drain_thr_i | input | TILE_W | Remaining-tile threshold for drain |
| preempt_req_i | input | 1 | Preemption request for the running task |
| tile_done_i | input | 1 | Tile completion pulse from the array |
| save_req_o | output | 1 | Context save request |
| save_ack_i | input | 1 | Context save acknowledge |
| restore_req_o | output | 1 | Context restore request |
| restore_ack_i | input | 1 | Context restore acknowledge |
| ctx_id_o | output | ID_W | Task of the current handshake |
| ctx_tile_o | output | TILE_W | Tile index saved or to be restored |
| run_valid_o | output | 1 | A task is computing |
| run_id_o | output | ID_W | Running task |
| run_tile_o | output | TILE_W | Tiles completed by the running task |
| act_valid_o | output | 1 | Preemption decision strobe |
| act_o | output | 2 | Decision: 0 checkpoint, 1 drain, 2 kill |
| done_valid_o | output | 1 | Task completion strobe |
| done_id_o | output | ID_W | Completed task |

## Verification
The bench builds the controller with eight slots, 2-bit tokens, 3-bit estimates and 4-bit tile counts. With such narrow fields, ties on tokens and estimates are common, so every rung of the selection order is exercised across several assignment patterns. The narrow tile count lets the bench sweep every threshold from 0 to 3, both kill-enable settings, every task length from 1 to 5 and every preemption point within the task. Each of the three decisions is then followed through to completion, including a checkpoint whose boundary tile finishes the task.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_CKPT, ST_SAVE, ST_DRAIN, ST_RESTORE
  } state_e;

  typedef enum logic [1:0] {
    ACT_CKPT  = 2'd0,
    ACT_DRAIN = 2'd1,
    ACT_KILL  = 2'd2
  } act_e;
endpackage

// File: rtl/tps_slot_table.sv
module tps_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 3,
  parameter int TOK_W     = 4,
  parameter int TILE_W    = 8,
  parameter int EST_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sub_valid_i,
  input  logic [ID_W-1:0]      sub_id_i,
  input  logic [TOK_W-1:0]     sub_tok_i,
  input  logic [TILE_W-1:0]    sub_tiles_i,
  input  logic [EST_W-1:0]     sub_est_i,
  input  logic                 sub_kill_en_i,
  input  logic [ID_W-1:0]      cmd_id_i,
  input  logic                 cmd_adv_i,
  input  logic                 cmd_free_i,
  input  logic                 cmd_kill_i,
  input  logic                 cmd_save_i,
  output logic [NUM_SLOTS-1:0] valid_o,
  output logic [NUM_SLOTS-1:0] kill_en_o,
  output logic [NUM_SLOTS-1:0] saved_o,
  output logic [TOK_W-1:0]     tok_o   [NUM_SLOTS],
  output logic [TILE_W-1:0]    total_o [NUM_SLOTS],
  output logic [TILE_W-1:0]    prog_o  [NUM_SLOTS],
  output logic [EST_W-1:0]     est_o   [NUM_SLOTS]
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic              valid_q, kill_q, saved_q;
    logic [TOK_W-1:0]  tok_q;
    logic [TILE_W-1:0] total_q, prog_q;
    logic [EST_W-1:0]  est_q;
    logic              wr_en, hit;

    assign wr_en = sub_valid_i && (sub_id_i == ID_W'(g)) && !valid_q && (sub_tiles_i != '0);
    assign hit   = (cmd_id_i == ID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        kill_q  <= 1'b0;
        saved_q <= 1'b0;
        tok_q   <= '0;
        total_q <= '0;
        prog_q  <= '0;
        est_q   <= '0;
      end else if (wr_en) begin
        valid_q <= 1'b1;
        kill_q  <= sub_kill_en_i;
        saved_q <= 1'b0;
        tok_q   <= sub_tok_i;
        total_q <= sub_tiles_i;
        prog_q  <= '0;
        est_q   <= sub_est_i;
      end else if (hit) begin
        if (cmd_free_i) valid_q <= 1'b0;
        if (cmd_kill_i) begin
          prog_q  <= '0;
          saved_q <= 1'b0;
        end else if (cmd_adv_i) begin
          prog_q <= prog_q + 1'b1;
        end
        if (cmd_save_i) saved_q <= 1'b1;
      end
    end

    assign valid_o[g]   = valid_q;
    assign kill_en_o[g] = kill_q;
    assign saved_o[g]   = saved_q;
    assign tok_o[g]     = tok_q;
    assign total_o[g]   = total_q;
    assign prog_o[g]    = prog_q;
    assign est_o[g]     = est_q;
  end
endmodule

// File: rtl/tps_pick.sv
module tps_pick #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 3,
  parameter int TOK_W     = 4,
  parameter int EST_W     = 8
) (
  input  logic [NUM_SLOTS-1:0] valid_i,
  input  logic [TOK_W-1:0]     tok_i [NUM_SLOTS],
  input  logic [EST_W-1:0]     est_i [NUM_SLOTS],
  output logic                 found_o,
  output logic [ID_W-1:0]      id_o
);
  logic [TOK_W-1:0] best_tok;
  logic [EST_W-1:0] best_est;

  // ascending scan with strict compares: equal candidates keep the lower slot
  always_comb begin
    found_o  = 1'b0;
    id_o     = '0;
    best_tok = '0;
    best_est = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (valid_i[i] && (!found_o || (tok_i[i] > best_tok) ||
                         ((tok_i[i] == best_tok) && (est_i[i] < best_est)))) begin
        found_o  = 1'b1;
        id_o     = ID_W'(i);
        best_tok = tok_i[i];
        best_est = est_i[i];
      end
    end
  end
endmodule

// File: rtl/tps_fsm.sv
module tps_fsm
  import tps_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int TILE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              found_i,
  input  logic [ID_W-1:0]   pick_id_i,
  input  logic              pick_saved_i,
  input  logic              tile_done_i,
  input  logic              preempt_req_i,
  input  logic [TILE_W-1:0] drain_thr_i,
  input  logic [TILE_W-1:0] run_total_i,
  input  logic [TILE_W-1:0] run_prog_i,
  input  logic              run_kill_en_i,
  input  logic              save_ack_i,
  input  logic              restore_ack_i,
  output logic [ID_W-1:0]   run_id_o,
  output logic              busy_o,
  output logic              cmd_adv_o,
  output logic              cmd_free_o,
  output logic              cmd_kill_o,
  output logic              cmd_save_o,
  output logic              act_valid_o,
  output logic [1:0]        act_o,
  output logic              done_o,
  output logic              save_req_o,
  output logic              restore_req_o
);
  state_e            st_q, st_d;
  logic [ID_W-1:0]   run_q, run_d;
  act_e              act;
  logic              adv, last;
  logic [TILE_W:0]   prog_inc;
  logic [TILE_W-1:0] prog_nxt, remaining;

  assign busy_o    = (st_q == ST_RUN) || (st_q == ST_CKPT) || (st_q == ST_DRAIN);
  assign adv       = tile_done_i && busy_o;
  assign prog_inc  = {1'b0, run_prog_i} + (TILE_W+1)'(1);
  assign last      = adv && (prog_inc == {1'b0, run_total_i});
  assign prog_nxt  = adv ? prog_inc[TILE_W-1:0] : run_prog_i;
  assign remaining = run_total_i - prog_nxt;

  always_comb begin
    st_d        = st_q;
    run_d       = run_q;
    cmd_free_o  = 1'b0;
    cmd_kill_o  = 1'b0;
    cmd_save_o  = 1'b0;
    act_valid_o = 1'b0;
    act         = ACT_CKPT;
    unique case (st_q)
      ST_IDLE: begin
        if (found_i) begin
          run_d = pick_id_i;
          st_d  = pick_saved_i ? ST_RESTORE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (last) begin
          cmd_free_o = 1'b1;
          st_d       = ST_IDLE;
        end else if (preempt_req_i) begin
          act_valid_o = 1'b1;
          if (remaining <= drain_thr_i) begin
            act  = ACT_DRAIN;
            st_d = ST_DRAIN;
          end else if (run_kill_en_i) begin
            act        = ACT_KILL;
            cmd_kill_o = 1'b1;
            st_d       = ST_IDLE;
          end else begin
            act  = ACT_CKPT;
            // a tile finishing this cycle is itself the boundary
            st_d = adv ? ST_SAVE : ST_CKPT;
          end
        end
      end
      ST_CKPT: begin
        if (last) begin
          cmd_free_o = 1'b1;
          st_d       = ST_IDLE;
        end else if (adv) begin
          st_d = ST_SAVE;
        end
      end
      ST_DRAIN: begin
        if (last) begin
          cmd_free_o = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      ST_SAVE: begin
        if (save_ack_i) begin
          cmd_save_o = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      ST_RESTORE: begin
        if (restore_ack_i) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      run_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign cmd_adv_o     = adv;
  assign done_o        = last;
  assign act_o         = act;
  assign run_id_o      = run_q;
  assign save_req_o    = (st_q == ST_SAVE);
  assign restore_req_o = (st_q == ST_RESTORE);
endmodule

// File: rtl/task_preempt_ctrl.sv
module task_preempt_ctrl #(
  parameter int NUM_SLOTS = 8,
  parameter int TOK_W     = 4,
  parameter int TILE_W    = 8,
  parameter int EST_W     = 8,
  localparam int ID_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_valid_i,
  input  logic [ID_W-1:0]   sub_id_i,
  input  logic [TOK_W-1:0]  sub_tok_i,
  input  logic [TILE_W-1:0] sub_tiles_i,
  input  logic [EST_W-1:0]  sub_est_i,
  input  logic              sub_kill_en_i,
  input  logic [TILE_W-1:0] drain_thr_i,
  input  logic              preempt_req_i,
  input  logic              tile_done_i,
  output logic              save_req_o,
  input  logic              save_ack_i,
  output logic              restore_req_o,
  input  logic              restore_ack_i,
  output logic [ID_W-1:0]   ctx_id_o,
  output logic [TILE_W-1:0] ctx_tile_o,
  output logic              run_valid_o,
  output logic [ID_W-1:0]   run_id_o,
  output logic [TILE_W-1:0] run_tile_o,
  output logic              act_valid_o,
  output logic [1:0]        act_o,
  output logic              done_valid_o,
  output logic [ID_W-1:0]   done_id_o
);
  logic [NUM_SLOTS-1:0] valid, kill_en, saved;
  logic [TOK_W-1:0]     tok   [NUM_SLOTS];
  logic [TILE_W-1:0]    total [NUM_SLOTS];
  logic [TILE_W-1:0]    prog  [NUM_SLOTS];
  logic [EST_W-1:0]     est   [NUM_SLOTS];
  logic                 found;
  logic [ID_W-1:0]      pick_id, run_id;
  logic                 cmd_adv, cmd_free, cmd_kill, cmd_save, busy;

  tps_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .TOK_W(TOK_W), .TILE_W(TILE_W), .EST_W(EST_W)
  ) u_table (
    .clk_i, .rst_ni, .sub_valid_i, .sub_id_i, .sub_tok_i, .sub_tiles_i, .sub_est_i,
    .sub_kill_en_i,
    .cmd_id_i  (run_id),
    .cmd_adv_i (cmd_adv),
    .cmd_free_i(cmd_free),
    .cmd_kill_i(cmd_kill),
    .cmd_save_i(cmd_save),
    .valid_o   (valid),
    .kill_en_o (kill_en),
    .saved_o   (saved),
    .tok_o     (tok),
    .total_o   (total),
    .prog_o    (prog),
    .est_o     (est)
  );

  tps_pick #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .TOK_W(TOK_W), .EST_W(EST_W)
  ) u_pick (
    .valid_i(valid),
    .tok_i  (tok),
    .est_i  (est),
    .found_o(found),
    .id_o   (pick_id)
  );

  tps_fsm #(.ID_W(ID_W), .TILE_W(TILE_W)) u_fsm (
    .clk_i, .rst_ni,
    .found_i       (found),
    .pick_id_i     (pick_id),
    .pick_saved_i  (saved[pick_id]),
    .tile_done_i,
    .preempt_req_i,
    .drain_thr_i,
    .run_total_i   (total[run_id]),
    .run_prog_i    (prog[run_id]),
    .run_kill_en_i (kill_en[run_id]),
    .save_ack_i,
    .restore_ack_i,
    .run_id_o      (run_id),
    .busy_o        (busy),
    .cmd_adv_o     (cmd_adv),
    .cmd_free_o    (cmd_free),
    .cmd_kill_o    (cmd_kill),
    .cmd_save_o    (cmd_save),
    .act_valid_o,
    .act_o,
    .done_o        (done_valid_o),
    .save_req_o,
    .restore_req_o
  );

  assign run_valid_o = busy;
  assign run_id_o    = run_id;
  assign run_tile_o  = prog[run_id];
  assign ctx_id_o    = run_id;
  assign ctx_tile_o  = prog[run_id];
  assign done_id_o   = run_id;
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tile_done_i,
  input logic       save_req_o,
  input logic       save_ack_i,
  input logic       restore_req_o,
  input logic       restore_ack_i,
  input logic       run_valid_o,
  input logic       act_valid_o,
  input logic [1:0] act_o,
  input logic       done_valid_o
);
  assert_hs_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_req_o && restore_req_o));

  assert_act_needs_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> run_valid_o);

  assert_kill_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_o && act_o == 2'd2) |=> (!run_valid_o && !save_req_o));

  assert_drain_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_o && act_o == 2'd1 && !done_valid_o) |=> run_valid_o);

  assert_save_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_req_o) |-> $past(tile_done_i));

  assert_save_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o && !save_ack_i) |=> save_req_o);

  assert_restore_resumes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_req_o && restore_ack_i) |=> run_valid_o);

  assert_done_on_tile_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> (tile_done_i && run_valid_o));

  assert_done_releases_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> !run_valid_o);
endmodule

bind task_preempt_ctrl tps_checker u_chk (.*);

// File: tb/sim_task_preempt_ctrl.sv
module sim_task_preempt_ctrl;
  localparam int NS = 8, TKW = 2, TW = 4, EW = 3, IW = 3;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic sub_valid_i, sub_kill_en_i, preempt_req_i, tile_done_i, save_ack_i, restore_ack_i;
  logic [IW-1:0]  sub_id_i;
  logic [TKW-1:0] sub_tok_i;
  logic [TW-1:0]  sub_tiles_i, drain_thr_i;
  logic [EW-1:0]  sub_est_i;
  logic save_req_o, restore_req_o, run_valid_o, act_valid_o, done_valid_o;
  logic [IW-1:0] ctx_id_o, run_id_o, done_id_o;
  logic [TW-1:0] ctx_tile_o, run_tile_o;
  logic [1:0]    act_o;

  int vecs = 0, errs = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  task_preempt_ctrl #(.NUM_SLOTS(NS), .TOK_W(TKW), .TILE_W(TW), .EST_W(EW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic submit(input int id, input int tk, input int tiles, input int es, input int kl);
    sub_id_i      = IW'(id);
    sub_tok_i     = TKW'(tk);
    sub_tiles_i   = TW'(tiles);
    sub_est_i     = EW'(es);
    sub_kill_en_i = kl[0];
    sub_valid_i   = 1'b1;
    tick();
    sub_valid_i   = 1'b0;
  endtask

  task automatic finish_tiles(input int id, input int from, input int total);
    for (int k = from; k < total; k++) begin
      tile_done_i = 1'b1;
      #1;
      chk("R4 done strobe", done_valid_o, int'(k == total - 1));
      if (k == total - 1) chk("R4 done id", done_id_o, id);
      else chk("R4 tile index", run_tile_o, k);
      tick();
      tile_done_i = 1'b0;
    end
    chk("R4 idle after completion", run_valid_o, 0);
  endtask

  task automatic run_case(input int id, input int thr, input int kl, input int total, input int pos);
    int rem, exp_act;
    drain_thr_i = TW'(thr);
    submit(id, 1, total, 2, kl);
    tick();
    chk("R3 dispatch valid", run_valid_o, 1);
    chk("R3 dispatch id", run_id_o, id);
    chk("R3 fresh start tile", run_tile_o, 0);
    chk("R3 no restore for fresh task", restore_req_o, 0);
    for (int k = 0; k < pos; k++) begin
      tile_done_i = 1'b1;
      tick();
      tile_done_i = 1'b0;
    end
    chk("R4 progress", run_tile_o, pos);
    rem = total - pos;
    exp_act = (rem <= thr) ? 1 : ((kl != 0) ? 2 : 0);
    preempt_req_i = 1'b1;
    #1;
    chk("R5 decision strobe", act_valid_o, 1);
    chk("R5 decision code", act_o, exp_act);
    tick();
    preempt_req_i = 1'b0;
    if (exp_act == 1) begin
      chk("R6 drain keeps running", run_valid_o, 1);
      preempt_req_i = 1'b1;
      #1;
      chk("R10 preempt ignored in drain", act_valid_o, 0);
      tick();
      preempt_req_i = 1'b0;
      finish_tiles(id, pos, total);
    end else if (exp_act == 2) begin
      chk("R9 kill stops", run_valid_o, 0);
      chk("R9 kill no save", save_req_o, 0);
      tick();
      chk("R9 redispatch", run_valid_o, 1);
      chk("R9 no restore", restore_req_o, 0);
      chk("R9 restart tile", run_tile_o, 0);
      finish_tiles(id, 0, total);
    end else begin
      chk("R7 runs until boundary", run_valid_o, 1);
      chk("R7 no early save", save_req_o, 0);
      preempt_req_i = 1'b1;
      #1;
      chk("R10 preempt ignored in ckpt wait", act_valid_o, 0);
      preempt_req_i = 1'b0;
      tile_done_i = 1'b1;
      #1;
      if (pos + 1 == total) begin
        chk("R7 boundary completes task", done_valid_o, 1);
        tick();
        tile_done_i = 1'b0;
        chk("R7 idle after completion", run_valid_o, 0);
        chk("R7 no save after completion", save_req_o, 0);
        return;
      end
      tick();
      tile_done_i = 1'b0;
      chk("R7 save request", save_req_o, 1);
      chk("R7 save id", ctx_id_o, id);
      chk("R7 save tile", ctx_tile_o, pos + 1);
      chk("R7 not running", run_valid_o, 0);
      tile_done_i = 1'b1;
      preempt_req_i = 1'b1;
      #1;
      chk("R10 preempt ignored in save", act_valid_o, 0);
      tick();
      tile_done_i = 1'b0;
      preempt_req_i = 1'b0;
      chk("R7 save held", save_req_o, 1);
      chk("R11 tile ignored in save", ctx_tile_o, pos + 1);
      chk("R11 no restore during save", restore_req_o, 0);
      save_ack_i = 1'b1;
      tick();
      save_ack_i = 1'b0;
      chk("R7 save released", save_req_o, 0);
      chk("R7 idle after save", run_valid_o, 0);
      tick();
      chk("R8 restore request", restore_req_o, 1);
      chk("R8 restore id", ctx_id_o, id);
      chk("R8 restore tile", ctx_tile_o, pos + 1);
      chk("R11 no save during restore", save_req_o, 0);
      restore_ack_i = 1'b1;
      tick();
      restore_ack_i = 1'b0;
      chk("R8 resumed", run_valid_o, 1);
      chk("R8 resume tile", run_tile_o, pos + 1);
      finish_tiles(id, pos + 1, total);
    end
  endtask

  task automatic arb_pattern(input int p);
    int tk[NS], es[NS];
    bit live[NS];
    int best, n;
    submit(0, 0, 1, 0, 0);
    tick();
    chk("R3 first dispatch", run_id_o, 0);
    submit(0, 3, 9, 0, 0);
    for (int i = 1; i < NS; i++) begin
      tk[i] = (p == 0) ? 1 : (i * 3 + p) % 4;
      es[i] = (p == 0) ? 3 : (i * 5 + 2 * p) % 8;
      live[i] = 1'b1;
      submit(i, tk[i], 1, es[i], 0);
    end
    finish_tiles(0, 0, 1);
    for (int r = 1; r < NS; r++) begin
      best = -1;
      for (int i = 1; i < NS; i++)
        if (live[i] && (best < 0 || tk[i] > tk[best] || (tk[i] == tk[best] && es[i] < es[best])))
          best = i;
      tick();
      chk("R3 arbitration valid", run_valid_o, 1);
      chk("R3 arbitration winner", run_id_o, best);
      live[best] = 1'b0;
      finish_tiles(best, 0, 1);
    end
    n = 0;
    tick();
    chk("R3 table drained", run_valid_o, n);
  endtask

  initial begin
    int id;
    rst_ni = 1'b0;
    sub_valid_i = 0; sub_kill_en_i = 0; preempt_req_i = 0; tile_done_i = 0;
    save_ack_i = 0; restore_ack_i = 0; sub_id_i = '0; sub_tok_i = '0;
    sub_tiles_i = '0; sub_est_i = '0; drain_thr_i = '0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 reset run", run_valid_o, 0);
    chk("R1 reset save", save_req_o, 0);
    chk("R1 reset restore", restore_req_o, 0);
    rst_ni = 1'b1;
    tick();
    tick();
    chk("R1 idle run", run_valid_o, 0);
    chk("R1 idle act", act_valid_o, 0);
    chk("R1 idle done", done_valid_o, 0);

    preempt_req_i = 1'b1;
    tile_done_i = 1'b1;
    #1;
    chk("R10 preempt ignored when idle", act_valid_o, 0);
    chk("R11 tile ignored when idle", done_valid_o, 0);
    tick();
    preempt_req_i = 1'b0;
    tile_done_i = 1'b0;

    submit(5, 1, 0, 1, 0);
    tick();
    chk("R2 zero-tile submit ignored", run_valid_o, 0);
    tick();
    chk("R2 zero-tile submit ignored", run_valid_o, 0);

    id = 0;
    for (int thr = 0; thr < 4; thr++)
      for (int kl = 0; kl < 2; kl++)
        for (int total = 1; total <= 5; total++)
          for (int pos = 0; pos < total; pos++) begin
            run_case(id % NS, thr, kl, total, pos);
            id++;
          end

    for (int p = 0; p < 6; p++) arb_pattern(p);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule